// File: doc/BRIEF.md
# General-Purpose I/O Port with Atomic Bit Set/Clear

This block is one sixteen-pin general-purpose I/O port. Software reaches it over a small word-addressed register bus. Each pin gets a 4-bit configuration nibble, and that nibble picks one of two directions:

- **Input:** analog, floating, or pulled.
- **Output:** push-pull or open-drain, fed either from the port's own output latch or from a peripheral's alternate-function signal.

From the configuration and the output latch, the port drives five per-pin pad control lines: driver enable, drive value, pull-up, pull-down and open-drain marker. Pad levels come back through a two-flop synchroniser into an input register that software can read.

There are two ways to change output bits. A plain write replaces the whole output latch. The other path is a write-only set/clear word, which raises or lowers any chosen bits in a single bus cycle, so concurrent owners of different pins need no read-modify-write. For a pin in pulled-input mode, the output latch bit chooses the pull direction.

Top module: `gpio_port`

## Requirements
- R1: After synchronous reset:
  - every configuration nibble is 4'b0100 (floating input), so both configuration words read 0x44444444;
  - the output latch reads 0;
  - no pad driver or pull is enabled.
- R2: Nibble placement:
  - pin n's nibble sits in bits 4*(n mod 8)+3 down to 4*(n mod 8);
  - pins 0 to 7 are in the word at address 0 and pins 8 to 15 in the word at address 1;
  - within a nibble, bits 1:0 are the direction/speed field (00 = input, any other value = output) and bits 3:2 are the sub-mode field.
- R3: A pin whose direction field is 00 never enables its driver and drives 0. With sub-mode 00 (analog) or 01 (floating) it enables no pull.
- R4: With direction 00 and sub-mode 10, the pull follows the pin's output latch bit:
  - latch bit 1 enables the pull-up only;
  - latch bit 0 enables the pull-down only;
  - no pin ever enables a pull together with its driver or with the other pull.
- R5: An output pin with sub-mode 00 enables its driver, drives its output latch bit, and does not assert open-drain.
- R6: An output pin with sub-mode bit 2 set asserts open-drain. It enables its driver only while its selected value is 0, and then drives 0.
- R7: An output pin with sub-mode bit 3 set takes its value from its alt_do bit and ignores its output latch bit. This holds in both push-pull (sub-mode 10) and open-drain (sub-mode 11).
- R8: A bus write to address 4 acts on the output latch from the next cycle:
  - data bit n (n < 16) sets latch bit n;
  - data bit 16+n clears latch bit n;
  - if both bits are set, the pin ends high;
  - bits with both data bits 0 keep their value.
- R9: Address 4 is write-only and reads as 0.
- R10: The register at address 2 returns the pad levels as they were two clock edges earlier. This includes pins configured as open-drain outputs.
- R11: A write to address 3 replaces the output latch with data bits 15:0. Reads of address 3 return the latch in bits 15:0 with zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address: 0 cfg low, 1 cfg high, 2 input, 3 output latch, 4 set/clear |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pad_di | input | 16 | Pad levels seen at the pins |
| alt_do | input | 16 | Peripheral output values for alternate-function pins |
| pad_oe | output | 16 | Pad driver enable per pin |
| pad_do | output | 16 | Pad drive value per pin |
| pad_pu | output | 16 | Pull-up enable per pin |
| pad_pd | output | 16 | Pull-down enable per pin |
| pad_od | output | 16 | Open-drain marker per pin |

## Verification
The properties below are checked on every cycle, against whatever configuration is live:
- the set/clear write semantics on the output latch, including set-over-clear and the untouched bits staying stable;
- a direct latch write;
- the zero readback of the set/clear address;
- the two-edge synchroniser delay;
- the electrical invariants that an open-drain pin never drives high and that pulls never coexist with a driver or with each other.

Only the bench scenarios can show the mode decode as a whole: which sub-mode selects which pad pattern, nibble placement across both configuration words, pull direction following the latch, and an alternate-function value overriding the latch.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    // Sub-mode encodings in nibble bits 3:2
    localparam logic [1:0] SUB_ANALOG = 2'b00;
    localparam logic [1:0] SUB_FLOAT  = 2'b01;
    localparam logic [1:0] SUB_PULL   = 2'b10;
    localparam logic [1:0] DIR_INPUT  = 2'b00;

    typedef struct packed {
        logic [1:0] sub;   // bits 3:2
        logic [1:0] dir;   // bits 1:0, 00 = input, else output speed code
    } pin_cfg_t;

    localparam pin_cfg_t CFG_RESET = '{sub: SUB_FLOAT, dir: DIR_INPUT};

    typedef struct packed {
        logic oe;
        logic dout;
        logic pu;
        logic pd;
        logic od;
    } pad_ctl_t;

    typedef enum logic [2:0] {
        RA_CFG_LO = 3'd0,
        RA_CFG_HI = 3'd1,
        RA_INPUT  = 3'd2,
        RA_OUTPUT = 3'd3,
        RA_SETCLR = 3'd4
    } reg_addr_e;

    function automatic pad_ctl_t pin_decode(pin_cfg_t c, logic latch_bit, logic alt_bit);
        pad_ctl_t p;
        logic     val;
        p   = '0;
        val = 1'b0;
        if (c.dir == DIR_INPUT) begin
            if (c.sub == SUB_PULL) begin
                p.pu = latch_bit;
                p.pd = !latch_bit;
            end
        end else begin
            val    = c.sub[1] ? alt_bit : latch_bit;
            p.od   = c.sub[0];
            p.oe   = c.sub[0] ? !val : 1'b1;
            p.dout = c.sub[0] ? 1'b0 : val;
        end
        return p;
    endfunction

endpackage

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
    import gpio_pkg::*;
#(
    parameter int NPINS  = 16,
    parameter int WORD_W = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [2:0]               wr_addr,
    input  logic [WORD_W-1:0]        wr_data,
    output logic [NPINS*4-1:0]       cfg_flat
);
    localparam int NIB_PER_WORD = WORD_W / 4;
    localparam int NWORDS       = (NPINS + NIB_PER_WORD - 1) / NIB_PER_WORD;

    logic [NWORDS*WORD_W-1:0] cfg_q;

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                cfg_q[w*WORD_W +: WORD_W] <= {NIB_PER_WORD{CFG_RESET}};
            else if (wr_en && wr_addr == 3'(int'(RA_CFG_LO) + w))
                cfg_q[w*WORD_W +: WORD_W] <= wr_data;
        end
    end

    assign cfg_flat = cfg_q[NPINS*4-1:0];

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
    import gpio_pkg::*;
#(
    parameter int NPINS  = 16,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [NPINS-1:0]  latch_q
);
    localparam int CLR_OFS = WORD_W / 2;

    logic [NPINS-1:0] set_bits;
    logic [NPINS-1:0] clr_bits;

    assign set_bits = wr_data[NPINS-1:0];
    assign clr_bits = wr_data[CLR_OFS +: NPINS];

    always_ff @(posedge clk) begin
        if (rst)
            latch_q <= '0;
        else if (wr_en && wr_addr == RA_OUTPUT)
            latch_q <= set_bits;
        else if (wr_en && wr_addr == RA_SETCLR)
            latch_q <= (latch_q & ~clr_bits) | set_bits;   // set dominates
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int NPINS  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] sync_q
);
    logic [NPINS-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= pad_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_pin_ctl.sv
module gpio_pin_ctl
    import gpio_pkg::*;
(
    input  pin_cfg_t cfg,
    input  logic     latch_bit,
    input  logic     alt_bit,
    output logic     oe,
    output logic     dout,
    output logic     pu,
    output logic     pd,
    output logic     od
);
    pad_ctl_t ctl;

    always_comb ctl = pin_decode(cfg, latch_bit, alt_bit);

    assign oe   = ctl.oe;
    assign dout = ctl.dout;
    assign pu   = ctl.pu;
    assign pd   = ctl.pd;
    assign od   = ctl.od;

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int NPINS       = 16,   // 9 to 16: two configuration words
    parameter int WORD_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pad_di,
    input  logic [NPINS-1:0]  alt_do,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_do,
    output logic [NPINS-1:0]  pad_pu,
    output logic [NPINS-1:0]  pad_pd,
    output logic [NPINS-1:0]  pad_od
);
    localparam int CFG_W = NPINS * 4;
    localparam int PAD_Z = WORD_W - NPINS;

    logic                 wr_en;
    logic [CFG_W-1:0]     cfg_flat;
    logic [NPINS-1:0]     out_q;
    logic [NPINS-1:0]     in_q;
    logic [2*WORD_W-1:0]  cfg_words;

    assign wr_en = bus_sel && bus_wr;

    gpio_cfg_bank #(.NPINS(NPINS), .WORD_W(WORD_W)) cfg_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(bus_addr),
        .wr_data(bus_wdata), .cfg_flat(cfg_flat)
    );

    gpio_out_latch #(.NPINS(NPINS), .WORD_W(WORD_W)) latch_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(bus_addr),
        .wr_data(bus_wdata), .latch_q(out_q)
    );

    gpio_in_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .pad_in(pad_di), .sync_q(in_q)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        gpio_pin_ctl pin_i (
            .cfg      (pin_cfg_t'(cfg_flat[p*4 +: 4])),
            .latch_bit(out_q[p]),
            .alt_bit  (alt_do[p]),
            .oe       (pad_oe[p]),
            .dout     (pad_do[p]),
            .pu       (pad_pu[p]),
            .pd       (pad_pd[p]),
            .od       (pad_od[p])
        );
    end

    // Unused nibbles of the high word read back as the floating-input code
    assign cfg_words = {{(2*WORD_W-CFG_W)/4{CFG_RESET}}, cfg_flat};

    always_comb begin
        case (bus_addr)
            RA_CFG_LO: bus_rdata = cfg_words[0 +: WORD_W];
            RA_CFG_HI: bus_rdata = cfg_words[WORD_W +: WORD_W];
            RA_INPUT:  bus_rdata = {{PAD_Z{1'b0}}, in_q};
            RA_OUTPUT: bus_rdata = {{PAD_Z{1'b0}}, out_q};
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_pkg::*;
#(
    parameter int NPINS       = 16,
    parameter int WORD_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [2:0]        bus_addr,
    input logic [WORD_W-1:0] bus_wdata,
    input logic [WORD_W-1:0] bus_rdata,
    input logic [NPINS-1:0]  pad_di,
    input logic [NPINS-1:0]  pad_oe,
    input logic [NPINS-1:0]  pad_do,
    input logic [NPINS-1:0]  pad_pu,
    input logic [NPINS-1:0]  pad_pd,
    input logic [NPINS-1:0]  pad_od,
    input logic [NPINS-1:0]  out_q,
    input logic [NPINS-1:0]  in_q
);
    localparam int CLR_OFS = WORD_W / 2;

    logic             sc_wr;
    logic             out_wr;
    logic [NPINS-1:0] w_set;
    logic [NPINS-1:0] w_clr;

    assign sc_wr  = bus_sel && bus_wr && bus_addr == RA_SETCLR;
    assign out_wr = bus_sel && bus_wr && bus_addr == RA_OUTPUT;
    assign w_set  = bus_wdata[NPINS-1:0];
    assign w_clr  = bus_wdata[CLR_OFS +: NPINS];

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pad_oe == '0 && pad_pu == '0 && pad_pd == '0 && out_q == '0));

    // R8
    setclr_set_chk: assert property (@(posedge clk) disable iff (rst)
        sc_wr |=> ((out_q & $past(w_set)) == $past(w_set)));

    // R8
    setclr_clr_chk: assert property (@(posedge clk) disable iff (rst)
        sc_wr |=> ((out_q & $past(w_clr) & ~$past(w_set)) == '0));

    // R8
    setclr_keep_chk: assert property (@(posedge clk) disable iff (rst)
        sc_wr |=> (((out_q ^ $past(out_q)) & ~($past(w_set) | $past(w_clr))) == '0));

    // R11
    out_direct_chk: assert property (@(posedge clk) disable iff (rst)
        out_wr |=> (out_q == $past(w_set)));

    // R9
    setclr_rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_wr && bus_addr == RA_SETCLR) |-> (bus_rdata == '0));

    // R6
    od_no_high_chk: assert property (@(posedge clk) disable iff (rst)
        ((pad_od & pad_oe & pad_do) == '0));

    // R4
    pull_excl_chk: assert property (@(posedge clk) disable iff (rst)
        (((pad_pu & pad_pd) | ((pad_pu | pad_pd) & pad_oe)) == '0));

    if (SYNC_STAGES == 2) begin : g_sync2
        // R10
        in_delay_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(rst, 2)) |-> (in_q == $past(pad_di, 2)));
    end

endmodule

bind gpio_port gpio_port_chk #(
    .NPINS(NPINS), .WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)
) chk_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_di(pad_di), .pad_oe(pad_oe), .pad_do(pad_do), .pad_pu(pad_pu),
    .pad_pd(pad_pd), .pad_od(pad_od), .out_q(out_q), .in_q(in_q)
);

// File: tb/gpio_port_tb.sv
module gpio_port_tb_top;

    localparam int NP = 16;

    localparam int S_RD = 0;
    localparam int S_OE = 1;
    localparam int S_DO = 2;
    localparam int S_PU = 3;
    localparam int S_PD = 4;
    localparam int S_OD = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NP-1:0] pad_di = '0;
    logic [NP-1:0] alt_do = '0;
    logic [NP-1:0] pad_oe, pad_do, pad_pu, pad_pd, pad_od;

    always #4 clk = ~clk;   // 125 MHz

    gpio_port dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_di(pad_di), .alt_do(alt_do), .pad_oe(pad_oe), .pad_do(pad_do),
        .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_od(pad_od)
    );

    typedef struct {
        int          sel;
        logic [31:0] mask;
        logic [31:0] exp;
        string       req;
    } exp_item_t;

    exp_item_t sb_q[$];
    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    // model state, built from the requirements
    logic [31:0] m_cfg_lo = 32'h4444_4444;
    logic [31:0] m_cfg_hi = 32'h4444_4444;
    logic [15:0] m_out    = '0;

    function automatic logic [31:0] put_nib(logic [31:0] w, int idx, logic [3:0] v);
        logic [31:0] r = w;
        r[idx*4 +: 4] = v;
        return r;
    endfunction

    function automatic logic [31:0] observe(int sel);
        case (sel)
            S_RD:    return bus_rdata;
            S_OE:    return {16'h0, pad_oe};
            S_DO:    return {16'h0, pad_do};
            S_PU:    return {16'h0, pad_pu};
            S_PD:    return {16'h0, pad_pd};
            default: return {16'h0, pad_od};
        endcase
    endfunction

    // monitor: compares queued expectations shortly after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (sb_q.size() > 0) begin
                exp_item_t it;
                logic [31:0] act;
                it  = sb_q.pop_front();
                act = observe(it.sel) & it.mask;
                n_checks++;
                if (act !== (it.exp & it.mask)) begin
                    n_errors++;
                    $display("FAIL %s sel=%0d actual=%h expected=%h",
                             it.req, it.sel, act, it.exp & it.mask);
                end
            end
        end
    end

    task automatic push(int sel, logic [31:0] mask, logic [31:0] exp, string req);
        exp_item_t it;
        it.sel = sel; it.mask = mask; it.exp = exp; it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic bus_write(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic read_chk(logic [2:0] a, logic [31:0] exp, string req);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        push(S_RD, 32'hFFFF_FFFF, exp, req);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic pad_chk(int sel, logic [15:0] mask, logic [15:0] exp, string req);
        push(sel, {16'h0, mask}, {16'h0, exp}, req);
        @(negedge clk);
    endtask

    task automatic set_clr(logic [15:0] s, logic [15:0] c);
        bus_write(3'd4, {c, s});
        m_out = (m_out & ~c) | s;
    endtask

    task automatic wr_lo(int pin, logic [3:0] v);
        m_cfg_lo = put_nib(m_cfg_lo, pin, v);
        bus_write(3'd0, m_cfg_lo);
    endtask

    task automatic wr_hi(int pin, logic [3:0] v);
        m_cfg_hi = put_nib(m_cfg_hi, pin - 8, v);
        bus_write(3'd1, m_cfg_hi);
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        read_chk(3'd0, 32'h4444_4444, "R1 cfg low");
        read_chk(3'd1, 32'h4444_4444, "R1 cfg high");
        read_chk(3'd3, 32'h0, "R1 output latch");
        pad_chk(S_OE, 16'hFFFF, 16'h0, "R1 no driver");
        pad_chk(S_PU, 16'hFFFF, 16'h0, "R1 no pull-up");
        pad_chk(S_PD, 16'hFFFF, 16'h0, "R1 no pull-down");

        // R2 / R5 nibble placement and push-pull
        wr_lo(3, 4'h3);
        read_chk(3'd0, m_cfg_lo, "R2 cfg low readback");
        wr_hi(10, 4'h1);
        read_chk(3'd1, m_cfg_hi, "R2 cfg high readback");
        pad_chk(S_OE, 16'hFFFF, 16'h0408, "R2 R5 driver per pin");
        pad_chk(S_OD, 16'hFFFF, 16'h0, "R5 no open-drain");

        // R8 set/clear
        set_clr(16'h0408, 16'h0);
        read_chk(3'd3, {16'h0, m_out}, "R8 set bits");
        pad_chk(S_DO, 16'hFFFF, 16'h0408, "R5 drive follows latch");
        set_clr(16'h0, 16'h0008);
        read_chk(3'd3, {16'h0, m_out}, "R8 clear bit");
        pad_chk(S_DO, 16'h0008, 16'h0, "R5 drive low after clear");
        set_clr(16'h0020, 16'h0020);
        read_chk(3'd3, {16'h0, m_out}, "R8 set wins over clear");
        read_chk(3'd4, 32'h0, "R9 set/clear reads zero");

        // R11 direct write
        bus_write(3'd3, 32'hFFFF_1234);
        m_out = 16'h1234;
        read_chk(3'd3, 32'h0000_1234, "R11 direct write");

        // R4 pull direction
        wr_lo(0, 4'h8);
        pad_chk(S_PD, 16'h0001, 16'h0001, "R4 pull-down when latch 0");
        pad_chk(S_PU, 16'h0001, 16'h0000, "R4 no pull-up when latch 0");
        set_clr(16'h0001, 16'h0);
        pad_chk(S_PU, 16'h0001, 16'h0001, "R4 pull-up when latch 1");
        pad_chk(S_PD, 16'h0001, 16'h0000, "R4 pull-down off when latch 1");
        pad_chk(S_OE, 16'h0001, 16'h0000, "R3 pull input has no driver");

        // R3 analog and floating
        wr_lo(1, 4'h0);
        pad_chk(S_PU, 16'h0006, 16'h0, "R3 analog/floating no pull-up");
        pad_chk(S_PD, 16'h0006, 16'h0, "R3 analog/floating no pull-down");
        pad_chk(S_OE, 16'h0006, 16'h0, "R3 analog/floating no driver");

        // R6 open-drain, latch bit 4 is 1 here
        wr_lo(4, 4'h7);
        pad_chk(S_OE, 16'h0010, 16'h0000, "R6 released when value 1");
        pad_chk(S_OD, 16'h0010, 16'h0010, "R6 open-drain marker");
        set_clr(16'h0, 16'h0010);
        pad_chk(S_OE, 16'h0010, 16'h0010, "R6 driven when value 0");
        pad_chk(S_DO, 16'h0010, 16'h0000, "R6 drives low");

        // R10 input path latency on an open-drain pin
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 3'd2;
        pad_di = 16'h0010;
        push(S_RD, 32'hFFFF_FFFF, 32'h0, "R10 not yet after one edge");
        @(negedge clk);
        push(S_RD, 32'hFFFF_FFFF, 32'h0000_0010, "R10 visible after two edges");
        @(negedge clk);
        bus_sel = 1'b0;

        // R7 alternate push-pull ignores the latch (latch bit 12 is 1)
        wr_hi(12, 4'hB);
        alt_do = 16'h0000;
        pad_chk(S_DO, 16'h1000, 16'h0000, "R7 alt value 0 overrides latch");
        alt_do = 16'h1000;
        @(negedge clk);
        pad_chk(S_DO, 16'h1000, 16'h1000, "R7 alt value 1");

        // R7 alternate open-drain
        wr_hi(13, 4'hF);
        pad_chk(S_OE, 16'h2000, 16'h2000, "R7 alt open-drain pulls low");
        alt_do = 16'h3000;
        @(negedge clk);
        pad_chk(S_OE, 16'h2000, 16'h0000, "R7 alt open-drain releases");
        pad_chk(S_OD, 16'h2000, 16'h2000, "R7 alt open-drain marker");

        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule